// File: doc/BRIEF.md
# NAND Program/Erase Completion Waiter

This block finishes off a program or erase that another agent has already started on a NAND flash device. When it receives a start request it places one status-read command cycle on the NAND bus. For an erase on a device of the multi-plane status family it uses opcode 0x71, and in every other case opcode 0x70. It then waits a fixed settling interval before it looks at the device at all. After that it watches for completion in one of two ways. In pin mode it watches a synchronized ready/busy pin. In poll mode it reads status bytes until one of them has the ready bit (bit 6, mask 0x40) set.

Once the device is seen ready, the block reads one more status byte and returns that byte as the result. A timeout bounds every wait. The limit is ERASE_MS milliseconds (400 by default) for an erase and OTHER_MS milliseconds (20 by default) for anything else. Time is counted in units of CLKS_PER_MS clocks. If the limit is reached first, the block returns the synthetic status 0x01 (fail bit) and issues no final read.

The start request and the result both use a valid/ready handshake. A start is taken only when the block is idle, which means that any previous result has already been accepted. The result stays valid with a stable status byte until it is accepted, so a slow consumer simply stalls the block. The bus request port also uses valid/ready: a request holds its kind and byte until it is accepted. The bus returns one response byte on a one-cycle response-valid strobe for each accepted read. At most one read is outstanding at any time.

Top module: `nand_done_waiter`

## Requirements
- R1: start_ready is high only when no operation is in progress and no result is pending. The result (res_valid with res_status) is held stable until res_ready is sampled high, and then res_valid drops and start_ready returns in the next cycle.
- R2: The first bus request after a start is a command cycle (bus_read=0). Its byte is 0x71 when start_erase and start_multi_fam were both 1 at the start, and 0x70 otherwise.
- R3: No read request is issued and the pin is not considered until at least TWB_CYCLES clocks after the command cycle is accepted.
- R4: In pin mode (start_pin_mode=1), no status byte is read while waiting. Once the synchronized dev_ready is high, exactly one status read is issued and its byte is the result.
- R5: In poll mode, reads are repeated while the returned byte has bit 6 clear. After a byte with bit 6 set, one further read is issued and its byte is the result.
- R6: The wait expires ERASE_MS*CLKS_PER_MS clocks after the command cycle is accepted for an erase, and OTHER_MS*CLKS_PER_MS clocks after it for other operations.
- R7: On expiry the result is 0x01 and no final status read is issued.
- R8: When expiry and a ready indication are evaluated in the same cycle, expiry wins and the result is 0x01.
- R9: A bus request that is not accepted keeps bus_valid high with bus_read and bus_byte unchanged, and at most one read is outstanding.
- R10: After reset, start_ready=1, bus_valid=0 and res_valid=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_valid | input | 1 | Start request valid |
| start_ready | output | 1 | Start request accepted when high |
| start_erase | input | 1 | Operation being completed is an erase |
| start_multi_fam | input | 1 | Device belongs to the multi-plane status family |
| start_pin_mode | input | 1 | 1: watch the ready/busy pin, 0: poll the status byte |
| bus_valid | output | 1 | Bus request valid |
| bus_ready | input | 1 | Bus request accepted |
| bus_read | output | 1 | 1: read one byte, 0: command latch cycle |
| bus_byte | output | 8 | Command byte for a command cycle |
| rsp_valid | input | 1 | Read data strobe, one cycle per accepted read |
| rsp_data | input | 8 | Byte read from the device |
| dev_ready | input | 1 | Ready/busy pin, high when ready (asynchronous) |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Result accepted when high |
| res_status | output | 8 | Final status byte, or 0x01 on timeout |

## Verification
The interesting collision is between the deadline and a ready indication: both are judged in the same state, and the expired flag is sticky. The bench delays a poll response that carries the ready bit until well past the 20 ms deadline, so expiry and readiness are presented to the sequencer together. It expects 0x01 as the result and exactly one read, with no final read. A second collision comes from keeping res_ready low while a result is pending: the status must not move and a new start must not be taken.

// File: rtl/nand_done_waiter_pkg.sv
package nand_done_waiter_pkg;

  localparam logic [7:0] OP_STATUS       = 8'h70;
  localparam logic [7:0] OP_STATUS_MULTI = 8'h71;
  localparam logic [7:0] STATUS_TIMEOUT  = 8'h01;
  localparam int         READY_BIT       = 6;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CMD,
    ST_TWB,
    ST_PIN,
    ST_PREQ,
    ST_PRSP,
    ST_FREQ,
    ST_FRSP,
    ST_DONE
  } wait_state_t;

endpackage

// File: rtl/ndw_sync.sv
module ndw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else        sh <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sh[STAGES-1];
endmodule

// File: rtl/ndw_deadline.sv
module ndw_deadline #(
  parameter int CLKS_PER_MS = 100000,
  parameter int ERASE_MS    = 400,
  parameter int OTHER_MS    = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic long_op,
  output logic expired
);
  localparam int MAX_MS = (ERASE_MS > OTHER_MS) ? ERASE_MS : OTHER_MS;
  localparam int MS_W   = $clog2(MAX_MS + 1);
  localparam int PRE_W  = (CLKS_PER_MS > 1) ? $clog2(CLKS_PER_MS) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLKS_PER_MS - 1);

  logic [PRE_W-1:0] pre;
  logic [MS_W-1:0]  ms;
  logic [MS_W-1:0]  lim;
  logic             armed;
  logic             hit;

  assign hit     = (ms >= lim);
  assign expired = armed && hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre   <= '0;
      ms    <= '0;
      lim   <= '0;
      armed <= 1'b0;
    end else if (load) begin
      pre   <= '0;
      ms    <= '0;
      lim   <= long_op ? MS_W'(ERASE_MS) : MS_W'(OTHER_MS);
      armed <= 1'b1;
    end else if (armed && !hit) begin
      if (pre == PRE_LAST) begin
        pre <= '0;
        ms  <= ms + 1'b1;
      end else begin
        pre <= pre + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ndw_sequencer.sv
module ndw_sequencer
  import nand_done_waiter_pkg::*;
#(
  parameter int TWB_CYCLES = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_valid,
  output logic       start_ready,
  input  logic       start_erase,
  input  logic       start_multi_fam,
  input  logic       start_pin_mode,
  output logic       bus_valid,
  input  logic       bus_ready,
  output logic       bus_read,
  output logic [7:0] bus_byte,
  input  logic       rsp_valid,
  input  logic [7:0] rsp_data,
  input  logic       pin_ready,
  input  logic       expired,
  output logic       tmr_load,
  output logic       tmr_long,
  output logic       res_valid,
  input  logic       res_ready,
  output logic [7:0] res_status
);
  localparam int TWB_W = $clog2(TWB_CYCLES + 1) + 1;

  wait_state_t      state;
  logic [TWB_W-1:0] twb;
  logic             op_erase;
  logic             op_multi;
  logic             op_pin;
  logic [7:0]       status_q;

  assign start_ready = (state == ST_IDLE);
  assign res_valid   = (state == ST_DONE);
  assign res_status  = status_q;
  assign bus_valid   = (state == ST_CMD) || (state == ST_PREQ) || (state == ST_FREQ);
  assign bus_read    = (state != ST_CMD);
  assign bus_byte    = (state == ST_CMD) ? (op_multi ? OP_STATUS_MULTI : OP_STATUS) : 8'h00;
  assign tmr_load    = (state == ST_CMD) && bus_ready;
  assign tmr_long    = op_erase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      twb      <= '0;
      op_erase <= 1'b0;
      op_multi <= 1'b0;
      op_pin   <= 1'b0;
      status_q <= 8'h00;
    end else begin
      case (state)
        ST_IDLE: if (start_valid) begin
          op_erase <= start_erase;
          op_multi <= start_erase && start_multi_fam;
          op_pin   <= start_pin_mode;
          state    <= ST_CMD;
        end
        ST_CMD: if (bus_ready) begin
          twb   <= TWB_W'(TWB_CYCLES);
          state <= ST_TWB;
        end
        ST_TWB: begin
          if (twb <= TWB_W'(1)) state <= op_pin ? ST_PIN : ST_PREQ;
          else                  twb   <= twb - 1'b1;
        end
        ST_PIN: begin
          if (expired) begin
            status_q <= STATUS_TIMEOUT;
            state    <= ST_DONE;
          end else if (pin_ready) begin
            state <= ST_FREQ;
          end
        end
        ST_PREQ: if (bus_ready) state <= ST_PRSP;
        ST_PRSP: if (rsp_valid) begin
          if (expired) begin
            status_q <= STATUS_TIMEOUT;
            state    <= ST_DONE;
          end else if (rsp_data[READY_BIT]) begin
            state <= ST_FREQ;
          end else begin
            state <= ST_PREQ;
          end
        end
        ST_FREQ: if (bus_ready) state <= ST_FRSP;
        ST_FRSP: if (rsp_valid) begin
          status_q <= rsp_data;
          state    <= ST_DONE;
        end
        ST_DONE: if (res_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nand_done_waiter.sv
module nand_done_waiter #(
  parameter int CLKS_PER_MS = 100000,
  parameter int ERASE_MS    = 400,
  parameter int OTHER_MS    = 20,
  parameter int TWB_CYCLES  = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_valid,
  output logic       start_ready,
  input  logic       start_erase,
  input  logic       start_multi_fam,
  input  logic       start_pin_mode,
  output logic       bus_valid,
  input  logic       bus_ready,
  output logic       bus_read,
  output logic [7:0] bus_byte,
  input  logic       rsp_valid,
  input  logic [7:0] rsp_data,
  input  logic       dev_ready,
  output logic       res_valid,
  input  logic       res_ready,
  output logic [7:0] res_status
);
  logic pin_ready;
  logic expired;
  logic tmr_load;
  logic tmr_long;

  ndw_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(dev_ready), .q(pin_ready)
  );

  ndw_deadline #(
    .CLKS_PER_MS(CLKS_PER_MS), .ERASE_MS(ERASE_MS), .OTHER_MS(OTHER_MS)
  ) u_deadline (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .long_op(tmr_long), .expired(expired)
  );

  ndw_sequencer #(.TWB_CYCLES(TWB_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .start_valid(start_valid), .start_ready(start_ready),
    .start_erase(start_erase), .start_multi_fam(start_multi_fam),
    .start_pin_mode(start_pin_mode),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_read(bus_read), .bus_byte(bus_byte),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .pin_ready(pin_ready), .expired(expired),
    .tmr_load(tmr_load), .tmr_long(tmr_long),
    .res_valid(res_valid), .res_ready(res_ready), .res_status(res_status)
  );
endmodule

// File: rtl/nand_done_waiter_chk.sv
module nand_done_waiter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_ready,
  input logic       bus_valid,
  input logic       bus_ready,
  input logic       bus_read,
  input logic [7:0] bus_byte,
  input logic       res_valid,
  input logic       res_ready,
  input logic [7:0] res_status
);
  // R9
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_read) && $stable(bus_byte));

  // R9
  single_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_ready && bus_read |=> !bus_valid);

  // R1
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_status));

  // R1
  idle_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_ready |-> !res_valid && !bus_valid);

  // R2
  opcode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_read |-> (bus_byte == 8'h70) || (bus_byte == 8'h71));
endmodule

bind nand_done_waiter nand_done_waiter_chk u_chk (.*);

// File: tb/nand_done_waiter_test.sv
module nand_done_waiter_test;
  localparam int CPM = 4, E_MS = 400, O_MS = 20, TWB = 10;
  localparam int L_ERASE = CPM * E_MS, L_OTHER = CPM * O_MS;

  logic clk = 0, rst_n = 0;
  logic start_valid = 0, start_erase = 0, start_multi_fam = 0, start_pin_mode = 0;
  logic start_ready, bus_valid, bus_read, res_valid;
  logic bus_ready, rsp_valid, dev_ready;
  logic [7:0] bus_byte, rsp_data, res_status;
  logic res_ready = 0;

  int checks = 0, fails = 0, cyc = 0;
  int n_cmd, n_rd, t_cmd, t_first_rd, busy_reads, rsp_delay, stall_left, pin_cd;
  int rsp_wait; bit rsp_pend; logic [7:0] rsp_byte, last_cmd, ready_byte;
  logic [7:0] got_status; int got_delta;

  nand_done_waiter #(.CLKS_PER_MS(CPM), .ERASE_MS(E_MS), .OTHER_MS(O_MS),
                     .TWB_CYCLES(TWB), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_ready(start_ready),
    .start_erase(start_erase), .start_multi_fam(start_multi_fam), .start_pin_mode(start_pin_mode),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_read(bus_read), .bus_byte(bus_byte),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .dev_ready(dev_ready),
    .res_valid(res_valid), .res_ready(res_ready), .res_status(res_status));

  always #5 clk = ~clk;
  initial forever begin @(posedge clk); cyc++; end

  // device / bus model, driven on falling edges
  initial begin
    bus_ready = 0; rsp_valid = 0; rsp_data = 0; dev_ready = 1; rsp_pend = 0;
    forever begin
      @(negedge clk);
      rsp_valid = 0; bus_ready = 0;
      if (pin_cd > 0) begin pin_cd--; if (pin_cd == 0) dev_ready = 1; end
      if (rsp_pend) begin
        if (rsp_wait == 0) begin rsp_valid = 1; rsp_data = rsp_byte; rsp_pend = 0; end
        else rsp_wait--;
      end else if (bus_valid) begin
        if (stall_left > 0) stall_left--;
        else begin
          bus_ready = 1;
          if (!bus_read) begin n_cmd++; last_cmd = bus_byte; t_cmd = cyc; end
          else begin
            n_rd++;
            if (n_rd == 1) t_first_rd = cyc;
            rsp_pend = 1; rsp_wait = rsp_delay;
            rsp_byte = (n_rd <= busy_reads) ? 8'h80 : ready_byte;
          end
        end
      end
    end
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0h expected=%0h", what, act, exp); end
  endtask

  task automatic run_op(input bit er, input bit fam, input bit pin, input int pin_after,
                        input int hold);
    int w;
    n_cmd = 0; n_rd = 0; t_cmd = 0; t_first_rd = 0;
    @(negedge clk);
    if (pin) begin dev_ready = 0; pin_cd = pin_after; end
    start_valid = 1; start_erase = er; start_multi_fam = fam; start_pin_mode = pin;
    @(negedge clk);
    start_valid = 0;
    w = 0;
    while (!res_valid && w < 4000) begin @(negedge clk); w++; end
    chk(res_valid, "result arrives (R1)", res_valid, 1);
    got_status = res_status; got_delta = cyc - t_cmd;
    if (hold > 0) begin
      repeat (hold) @(negedge clk);
      chk(res_valid && res_status == got_status, "R1 result held under back-pressure",
          res_status, got_status);
      chk(!start_ready, "R1 start blocked while result pending", start_ready, 0);
    end
    res_ready = 1; @(negedge clk); res_ready = 0;
    chk(!res_valid && start_ready, "R1 idle after accept", start_ready, 1);
    dev_ready = 1; pin_cd = 0;
  endtask

  task automatic t_reset();
    chk(start_ready == 1, "R10 start_ready after reset", start_ready, 1);
    chk(bus_valid == 0, "R10 bus_valid after reset", bus_valid, 0);
    chk(res_valid == 0, "R10 res_valid after reset", res_valid, 0);
  endtask

  task automatic t_pin_plain();
    busy_reads = 0; rsp_delay = 0; stall_left = 0; ready_byte = 8'hE0;
    run_op(0, 1, 1, 30, 0);
    chk(last_cmd == 8'h70, "R2 plain opcode for non-erase", last_cmd, 8'h70);
    chk(n_rd == 1, "R4 single read in pin mode", n_rd, 1);
    chk(got_status == 8'hE0, "R4 final byte returned", got_status, 8'hE0);
    chk(t_first_rd - t_cmd >= TWB, "R3 settle before first read", t_first_rd - t_cmd, TWB);
  endtask

  task automatic t_poll_multi();
    busy_reads = 3; rsp_delay = 1; stall_left = 0; ready_byte = 8'hC5;
    run_op(1, 1, 0, 0, 0);
    chk(last_cmd == 8'h71, "R2 multi opcode for family erase", last_cmd, 8'h71);
    chk(n_rd == 5, "R5 polls plus one final read", n_rd, 5);
    chk(got_status == 8'hC5, "R5 final byte returned", got_status, 8'hC5);
    chk(t_first_rd - t_cmd >= TWB, "R3 settle before first poll", t_first_rd - t_cmd, TWB);
  endtask

  task automatic t_erase_nofam();
    busy_reads = 0; rsp_delay = 0; stall_left = 0; ready_byte = 8'h41;
    run_op(1, 0, 1, 5, 0);
    chk(last_cmd == 8'h70, "R2 plain opcode for erase without family", last_cmd, 8'h70);
    chk(got_status == 8'h41, "R4 status after early pin", got_status, 8'h41);
  endtask

  task automatic t_timeout_pin();
    busy_reads = 0; rsp_delay = 0; stall_left = 0; ready_byte = 8'hE0;
    run_op(0, 0, 1, -1, 0);
    chk(got_status == 8'h01, "R7 timeout status", got_status, 8'h01);
    chk(n_rd == 0, "R7 no final read after expiry", n_rd, 0);
    chk(got_delta >= L_OTHER && got_delta <= L_OTHER + 6, "R6 short deadline", got_delta, L_OTHER);
  endtask

  task automatic t_timeout_poll_erase();
    busy_reads = 1000000; rsp_delay = 0; stall_left = 0; ready_byte = 8'hC0;
    run_op(1, 0, 0, 0, 0);
    chk(got_status == 8'h01, "R7 erase timeout status", got_status, 8'h01);
    chk(got_delta >= L_ERASE && got_delta <= L_ERASE + 8, "R6 long deadline", got_delta, L_ERASE);
  endtask

  task automatic t_collision();
    busy_reads = 0; rsp_delay = 200; stall_left = 0; ready_byte = 8'hC0;
    run_op(0, 0, 0, 0, 0);
    chk(got_status == 8'h01, "R8 expiry beats ready bit", got_status, 8'h01);
    chk(n_rd == 1, "R8 no final read after late ready", n_rd, 1);
  endtask

  task automatic t_backpressure();
    busy_reads = 0; rsp_delay = 0; stall_left = 6; ready_byte = 8'h60;
    run_op(0, 0, 0, 0, 10);
    chk(n_cmd == 1 && last_cmd == 8'h70, "R9 stalled command taken once", n_cmd, 1);
    chk(got_status == 8'h60, "R9 result after stalled command", got_status, 8'h60);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    busy_reads = 0; rsp_delay = 0; stall_left = 0; pin_cd = 0; ready_byte = 8'h40;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_pin_plain();
    t_poll_multi();
    t_erase_nofam();
    t_timeout_pin();
    t_timeout_poll_erase();
    t_collision();
    t_backpressure();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule